// File: doc/BRIEF.md
# Skip Predicate Instruction Suppressor

This block cancels individual instructions without redirecting the instruction stream. A skip-set command picks two bits out of the condition bit vector by index and joins them with one of eight two-input Boolean functions. The result is latched as the single active skip predicate. Every instruction that follows carries a skip flag. A flagged instruction is cancelled while the active predicate is true, and an unflagged instruction always goes ahead.

The predicate stays in force over any number of instructions until a new skip-set command replaces it. An exit-with-save-location command returns the block to the state with no predicate. The block produces one registered commit enable per instruction. The execution units gate their write-back and side effects with that enable.

Top module: `skip_suppress_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `commit_valid` and `commit_en` are 0 after that edge. After reset no predicate is active, so flagged instructions commit.
- R2: `commit_valid` equals the `ins_valid` sampled at the previous rising edge. When `ins_valid` was 0, `commit_en` is also 0.
- R3: An instruction with `ins_skip` = 0 always gives `commit_en` = 1 one cycle later.
- R4: The function code `set_func` is decoded as follows, with a = the first selected bit and b = the second: 0 = a AND b, 1 = a AND NOT b, 2 = NOR, 3 = OR, 4 = a OR NOT b, 5 = NAND, 6 = equality (XNOR), 7 = XOR. A flagged instruction is cancelled (`commit_en` = 0) exactly when the latched function value is 1.
- R5: `set_idx_a` and `set_idx_b` each select one bit of `cond_bits`, with bit 0 being the least significant. Indices 0 and COND_W-1 both work, and both indices may name the same bit.
- R6: The predicate value is captured from `cond_bits` at the edge where `set_valid` is sampled high. Later changes to `cond_bits` have no effect on it.
- R7: Only one predicate exists. A new skip-set command replaces the previous predicate entirely.
- R8: A predicate stays in force for any number of instructions until the next skip-set or clear command.
- R9: `clr_valid` (exit with save location) returns the block to the no-predicate state, and flagged instructions commit again.
- R10: A command takes effect from the next cycle. An instruction in the same cycle as a command uses the previous predicate state. When `set_valid` and `clr_valid` are high together, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_bits | input | COND_W | Condition bit vector |
| set_valid | input | 1 | Skip-set command strobe |
| set_func | input | 3 | Boolean function code of the skip-set command |
| set_idx_a | input | IDX_W | Index of the first condition bit |
| set_idx_b | input | IDX_W | Index of the second condition bit |
| clr_valid | input | 1 | Exit-with-save-location strobe: clears the predicate |
| ins_valid | input | 1 | Instruction present this cycle |
| ins_skip | input | 1 | Skip flag of the instruction |
| commit_valid | output | 1 | Registered copy of ins_valid |
| commit_en | output | 1 | Registered commit enable of the instruction |

## Verification
The bench builds the block with its default parameters: a 32-bit condition vector and 5-bit indices. At this width every index, including both end bits 0 and 31, can be driven directly. Every function code is swept against all four combinations of its two operand bits. Directed sequences cover latching, replacement, a long run under one predicate, clearing, and a set and a clear in the same cycle. A pseudo-random mix of commands and flagged and unflagged instructions then runs against the reference model, which is compared on every clock.

// File: rtl/skp_pkg.sv
package skp_pkg;

  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    SKP_AND  = 3'd0,
    SKP_ANDN = 3'd1,
    SKP_NOR  = 3'd2,
    SKP_OR   = 3'd3,
    SKP_ORN  = 3'd4,
    SKP_NAND = 3'd5,
    SKP_EQV  = 3'd6,
    SKP_XOR  = 3'd7
  } skp_func_e;

  typedef struct packed {
    logic active;
    logic value;
  } skp_pred_t;

endpackage

// File: rtl/skp_bit_pick.sv
module skp_bit_pick #(
  parameter int COND_W = 32,
  parameter int IDX_W  = $clog2(COND_W)
) (
  input  logic [COND_W-1:0] cond_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);

  logic [COND_W-1:0] hit;

  // One-hot match per bit position, then an OR tree.
  for (genvar i = 0; i < COND_W; i++) begin : g_hit
    assign hit[i] = (idx_i == IDX_W'(i)) & cond_i[i];
  end

  assign bit_o = |hit;

endmodule

// File: rtl/skp_func_eval.sv
module skp_func_eval
  import skp_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  input  logic              a_i,
  input  logic              b_i,
  output logic              y_o
);

  always_comb begin
    unique case (skp_func_e'(func_i))
      SKP_AND:  y_o = a_i & b_i;
      SKP_ANDN: y_o = a_i & ~b_i;
      SKP_NOR:  y_o = ~(a_i | b_i);
      SKP_OR:   y_o = a_i | b_i;
      SKP_ORN:  y_o = a_i | ~b_i;
      SKP_NAND: y_o = ~(a_i & b_i);
      SKP_EQV:  y_o = ~(a_i ^ b_i);
      SKP_XOR:  y_o = a_i ^ b_i;
      default:  y_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/skp_pred_state.sv
module skp_pred_state
  import skp_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_i,
  input  logic      set_val_i,
  input  logic      clr_i,
  output skp_pred_t pred_o
);

  skp_pred_t pred_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q <= '0;
    end else if (set_i) begin
      pred_q.active <= 1'b1;
      pred_q.value  <= set_val_i;
    end else if (clr_i) begin
      pred_q.active <= 1'b0;
      pred_q.value  <= 1'b0;
    end
  end

  assign pred_o = pred_q;

endmodule

// File: rtl/skip_suppress_unit.sv
module skip_suppress_unit
  import skp_pkg::*;
#(
  parameter int COND_W = 32,
  parameter int IDX_W  = $clog2(COND_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [COND_W-1:0] cond_bits,
  input  logic              set_valid,
  input  logic [FUNC_W-1:0] set_func,
  input  logic [IDX_W-1:0]  set_idx_a,
  input  logic [IDX_W-1:0]  set_idx_b,
  input  logic              clr_valid,
  input  logic              ins_valid,
  input  logic              ins_skip,
  output logic              commit_valid,
  output logic              commit_en
);

  localparam int NOPS = 2;

  logic [NOPS-1:0]  op_bit;
  logic [IDX_W-1:0] op_idx [NOPS];
  logic             pred_new;
  skp_pred_t        pred;
  logic             cancel;
  logic             valid_q;
  logic             en_q;

  assign op_idx[0] = set_idx_a;
  assign op_idx[1] = set_idx_b;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    skp_bit_pick #(.COND_W(COND_W), .IDX_W(IDX_W)) u_pick (
      .cond_i (cond_bits),
      .idx_i  (op_idx[k]),
      .bit_o  (op_bit[k])
    );
  end

  skp_func_eval u_eval (
    .func_i (set_func),
    .a_i    (op_bit[0]),
    .b_i    (op_bit[1]),
    .y_o    (pred_new)
  );

  skp_pred_state u_state (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_valid),
    .set_val_i (pred_new),
    .clr_i     (clr_valid),
    .pred_o    (pred)
  );

  // The instruction sees the predicate state held before this edge.
  assign cancel = ins_skip & pred.active & pred.value;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      valid_q <= ins_valid;
      en_q    <= ins_valid & ~cancel;
    end
  end

  assign commit_valid = valid_q;
  assign commit_en    = en_q;

endmodule

// File: rtl/skp_checker.sv
module skp_checker
  import skp_pkg::*;
#(
  parameter int COND_W = 32,
  parameter int IDX_W  = $clog2(COND_W)
) (
  input logic              clk,
  input logic              rst,
  input logic [COND_W-1:0] cond_bits,
  input logic              set_valid,
  input logic [FUNC_W-1:0] set_func,
  input logic [IDX_W-1:0]  set_idx_a,
  input logic [IDX_W-1:0]  set_idx_b,
  input logic              clr_valid,
  input logic              ins_valid,
  input logic              ins_skip,
  input logic              commit_valid,
  input logic              commit_en
);

  // R2
  commit_align_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (commit_valid == $past(ins_valid)));

  // R2
  en_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    commit_en |-> commit_valid);

  // R3
  unflagged_commits_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !ins_skip) |=> commit_en);

  // R9
  cleared_commits_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !set_valid) ##1 (ins_valid && !set_valid) |=> commit_en);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!commit_valid && !commit_en));

endmodule

bind skip_suppress_unit skp_checker #(.COND_W(COND_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/tb_skip_suppress_unit.sv
module tb_skip_suppress_unit;

  localparam int COND_W = 32;
  localparam int IDX_W  = 5;
  localparam int WDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst;
  logic [COND_W-1:0] cond_bits;
  logic              set_valid;
  logic [2:0]        set_func;
  logic [IDX_W-1:0]  set_idx_a;
  logic [IDX_W-1:0]  set_idx_b;
  logic              clr_valid;
  logic              ins_valid;
  logic              ins_skip;
  logic              commit_valid;
  logic              commit_en;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit m_act = 0;
  bit m_val = 0;

  always #5 clk = ~clk;

  skip_suppress_unit #(.COND_W(COND_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .cond_bits(cond_bits), .set_valid(set_valid),
    .set_func(set_func), .set_idx_a(set_idx_a), .set_idx_b(set_idx_b),
    .clr_valid(clr_valid), .ins_valid(ins_valid), .ins_skip(ins_skip),
    .commit_valid(commit_valid), .commit_en(commit_en)
  );

  function automatic bit ref_fn(int code, bit a, bit b);
    case (code)
      0: return a && b;
      1: return a && !b;
      2: return !(a || b);
      3: return a || b;
      4: return a || !b;
      5: return !(a && b);
      6: return a == b;
      default: return a != b;
    endcase
  endfunction

  task automatic check(string tag, bit ev, bit ee);
    checks++;
    if (commit_valid !== ev || commit_en !== ee) begin
      fails++;
      $display("FAIL %s: valid/en got %b/%b expected %b/%b", tag,
               commit_valid, commit_en, ev, ee);
    end
  endtask

  // Drive one cycle of inputs, advance the model at the edge, check at negedge.
  task automatic step(string tag, bit iv, bit is, bit sv, int fn, int ia, int ib,
                      bit cv, logic [COND_W-1:0] cb);
    bit ev, ee;
    ins_valid = iv; ins_skip = is; set_valid = sv; set_func = 3'(fn);
    set_idx_a = IDX_W'(ia); set_idx_b = IDX_W'(ib); clr_valid = cv; cond_bits = cb;
    @(posedge clk);
    ev = iv;
    ee = iv && !(is && m_act && m_val);
    if (sv) begin
      m_act = 1;
      m_val = ref_fn(fn, cb[ia], cb[ib]);
    end else if (cv) begin
      m_act = 0;
      m_val = 0;
    end
    @(negedge clk);
    check(tag, ev, ee);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WDOG);
        finish_run();
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst = 1; cond_bits = '0; set_valid = 0; set_func = 0; set_idx_a = 0;
    set_idx_b = 0; clr_valid = 0; ins_valid = 1; ins_skip = 1;
    // R1: outputs held low through reset even with an instruction present
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 reset", 1'b0, 1'b0);
    end
    rst = 0;
    // R1: flagged instruction commits with no predicate
    step("R1 no predicate", 1, 1, 0, 0, 0, 0, 0, '1);
    // R11/R2: idle cycle
    step("R2 idle", 0, 1, 0, 0, 0, 0, 0, '0);
    // R3: unflagged
    step("R3 unflagged", 1, 0, 0, 0, 0, 0, 0, '0);

    // R4: every function against every operand pair
    for (int fn = 0; fn < 8; fn++) begin
      for (int ab = 0; ab < 4; ab++) begin
        logic [COND_W-1:0] cb;
        cb = '0;
        cb[3]  = ab[1];
        cb[17] = ab[0];
        step("R4 set", 0, 0, 1, fn, 3, 17, 0, cb);
        step("R4 flagged", 1, 1, 0, 0, 0, 0, 0, ~cb);
        step("R3 under predicate", 1, 0, 0, 0, 0, 0, 0, ~cb);
      end
    end

    // R5: end indices and a shared index
    step("R5 set ends", 0, 0, 1, 0, 0, 31, 0, 32'h8000_0001);
    step("R5 ends flagged", 1, 1, 0, 0, 0, 0, 0, '0);
    step("R5 set ends", 0, 0, 1, 0, 0, 31, 0, 32'h8000_0000);
    step("R5 ends flagged", 1, 1, 0, 0, 0, 0, 0, '0);
    step("R5 same index", 0, 0, 1, 7, 9, 9, 0, 32'h0000_0200);
    step("R5 same flagged", 1, 1, 0, 0, 0, 0, 0, '0);

    // R6: latched value, condition bits then flip
    step("R6 set", 0, 0, 1, 3, 4, 5, 0, 32'h0000_0010);
    step("R6 flipped cond", 1, 1, 0, 0, 0, 0, 0, 32'h0000_0000);
    step("R6 flipped cond", 1, 1, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);

    // R7: replacement
    step("R7 replace", 0, 0, 1, 2, 4, 5, 0, 32'h0000_0010);
    step("R7 flagged", 1, 1, 0, 0, 0, 0, 0, '0);

    // R8: long run under one true predicate
    step("R8 set", 0, 0, 1, 0, 1, 2, 0, 32'h0000_0006);
    for (int i = 0; i < 60; i++)
      step("R8 run", 1, i[0], 0, 0, 0, 0, 0, 32'(i));

    // R9: clear
    step("R9 clear", 0, 0, 0, 0, 0, 0, 1, '0);
    step("R9 flagged", 1, 1, 0, 0, 0, 0, 0, '1);

    // R10: same-cycle command and instruction, set beats clear
    step("R10 set", 0, 0, 1, 3, 0, 1, 0, 32'h1);
    step("R10 instr with clear", 1, 1, 0, 0, 0, 0, 1, '0);
    step("R10 after clear", 1, 1, 0, 0, 0, 0, 0, '0);
    step("R10 instr with set", 1, 1, 1, 3, 0, 1, 0, 32'h1);
    step("R10 after set", 1, 1, 0, 0, 0, 0, 0, '0);
    step("R10 set and clear", 1, 1, 1, 2, 0, 1, 1, 32'h0);
    step("R10 set wins", 1, 1, 0, 0, 0, 0, 0, '0);

    // Mixed pseudo-random traffic
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R4 mix", lfsr[0], lfsr[1], lfsr[2:0] == 3'b101, int'(lfsr[7:5]),
           int'(lfsr[12:8]), int'(lfsr[17:13]), lfsr[4:2] == 3'b011,
           {lfsr[15:0], lfsr[31:16]});
    end

    finish_run();
  end

endmodule